// File: doc/BRIEF.md
# Paged Memory Address Mapper

This block turns a 16-bit processor address into an 18-bit physical memory address. Four small page registers are loaded through an I/O write port. On each memory access the two most significant processor address bits choose one of these registers, and its contents become the page number of the physical address. The fourteen offset bits are carried through unchanged. This gives the processor a window of four 16K pages, chosen from sixteen.

The same combinational path also classifies the physical page. The page is steered to main RAM, display RAM or boot ROM, or it is reported as unmapped. It also folds the page offset into the local address of the selected device. The 20K display RAM covers one full page and one page in which a 4K tail repeats. The 2K boot ROM repeats across the top four pages. Translation adds no register stage, so the physical address and the selects are valid in the same cycle as the processor address.

Top module: `paged_addr_mapper`

## Requirements
- R1: Each time reset is released, page register n holds n (n = 0..3). Logical page n therefore reaches physical page n, which is main RAM.
- R2: A write with `map_wr_en` high loads `map_wr_data[3:0]` into the page register chosen by `map_wr_sel` at the next rising clock edge. Bits 7:4 of the write data are ignored, and the other three registers keep their values.
- R3: `phys_addr[17:14]` equals the page register selected by `cpu_addr[15:14]`, and `phys_addr[13:0]` equals `cpu_addr[13:0]`. Both hold in the same cycle as `cpu_addr`, with no clock edge between them.
- R4: Physical pages 0x0 to 0x3 assert `sel_main`, and `dev_addr` equals `phys_addr[15:0]`.
- R5: Physical page 0x8 asserts `sel_disp`, and `dev_addr` equals `phys_addr[13:0]` zero-extended (display bytes 0 to 16383).
- R6: Physical page 0x9 asserts `sel_disp`, and `dev_addr` equals 0x4000 plus `phys_addr[11:0]`. Offset bits 13:12 are ignored, so the 4K tail repeats four times.
- R7: Physical pages 0xC to 0xF assert `sel_boot`, and `dev_addr` equals `phys_addr[10:0]` zero-extended.
- R8: Physical pages 0x4 to 0x7, 0xA and 0xB assert `unmapped`. All three device selects are low, and `dev_addr` is zero.
- R9: Exactly one of `sel_main`, `sel_disp`, `sel_boot` and `unmapped` is high at any time.
- R10: While `map_wr_en` is low, no page register changes, whatever `map_wr_sel` and `map_wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the page registers |
| rst_n | input | 1 | Active-low reset, loads the identity map |
| map_wr_en | input | 1 | Write strobe for a page register |
| map_wr_sel | input | 2 | Index of the page register to load |
| map_wr_data | input | 8 | Write data, the low 4 bits give the new page |
| cpu_addr | input | 16 | Logical processor address |
| phys_addr | output | 18 | Translated physical address |
| sel_main | output | 1 | Access falls in main RAM |
| sel_disp | output | 1 | Access falls in display RAM |
| sel_boot | output | 1 | Access falls in boot ROM |
| unmapped | output | 1 | Access falls in an unused page |
| dev_addr | output | 16 | Address inside the selected device |

## Verification
The bench targets the points where the folding is easy to get wrong.

- **Display tail page.** Addresses on the 4K tail page use offset bits 13:12 set to a non-zero value. A decoder that forgot to drop those bits would give a display address above 20K.
- **Boot ROM mirrors.** Boot addresses sit at the top of a 16K page. A decoder that masked too few bits would return an address past the 2K ROM.
- **Unused pages.** Every unused page is visited, including the gap pages 0xA and 0xB. A decoder with a missing case would raise a device select there, or leave a nonzero device address.
- **Register writes.** Writes carry junk in the upper data bits, and the write strobe is held low while a select and data are driven. A register file that used the wrong data bits, or that ignored the strobe, would move the page seen in `phys_addr`.
- **Reset.** Reset is applied a second time after the map has been changed. A design that loaded the identity map only at power-up would fail this check.

// File: rtl/paged_map_pkg.sv
package paged_map_pkg;

    localparam int PAGE_BITS = 4;

    typedef enum logic [2:0] {
        RGN_MAIN    = 3'd0,
        RGN_DISP_LO = 3'd1,
        RGN_DISP_HI = 3'd2,
        RGN_BOOT    = 3'd3,
        RGN_NONE    = 3'd4
    } region_e;

    // Classify a physical page number into the device region it addresses.
    function automatic region_e classify_page(input logic [PAGE_BITS-1:0] pg);
        region_e r;
        unique case (pg)
            4'h0, 4'h1, 4'h2, 4'h3: r = RGN_MAIN;
            4'h8:                   r = RGN_DISP_LO;
            4'h9:                   r = RGN_DISP_HI;
            4'hC, 4'hD, 4'hE, 4'hF: r = RGN_BOOT;
            default:                r = RGN_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pm_page_regs.sv
module pm_page_regs #(
    parameter int SEL_W  = 2,
    parameter int PAGE_W = 4,
    localparam int N_REG = 1 << SEL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [PAGE_W-1:0]       wr_page,
    output logic [N_REG*PAGE_W-1:0] regs_flat
);

    for (genvar i = 0; i < N_REG; i++) begin : g_reg
        localparam logic [PAGE_W-1:0] INIT_PAGE = PAGE_W'(i);
        localparam logic [SEL_W-1:0]  MY_IDX    = SEL_W'(i);
        logic [PAGE_W-1:0] page_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                page_q <= INIT_PAGE;
            end else if (wr_en && (wr_sel == MY_IDX)) begin
                page_q <= wr_page;
            end
        end

        assign regs_flat[i*PAGE_W +: PAGE_W] = page_q;
    end

endmodule

// File: rtl/pm_xlate.sv
module pm_xlate #(
    parameter int SEL_W  = 2,
    parameter int OFFS_W = 14,
    parameter int PAGE_W = 4,
    localparam int N_REG  = 1 << SEL_W,
    localparam int LOG_W  = SEL_W + OFFS_W,
    localparam int PHYS_W = PAGE_W + OFFS_W
) (
    input  logic [LOG_W-1:0]        cpu_addr,
    input  logic [N_REG*PAGE_W-1:0] regs_flat,
    output logic [PHYS_W-1:0]       phys_addr
);

    logic [SEL_W-1:0]  bank;
    logic [PAGE_W-1:0] page_sel;

    assign bank = cpu_addr[LOG_W-1:OFFS_W];

    always_comb begin
        page_sel = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (bank == SEL_W'(i)) begin
                page_sel = regs_flat[i*PAGE_W +: PAGE_W];
            end
        end
    end

    assign phys_addr = {page_sel, cpu_addr[OFFS_W-1:0]};

endmodule

// File: rtl/pm_region.sv
module pm_region
    import paged_map_pkg::*;
#(
    parameter int OFFS_W      = 14,
    parameter int DISP_TAIL_W = 12,
    parameter int BOOT_W      = 11,
    localparam int PAGE_W     = PAGE_BITS,
    localparam int PHYS_W     = PAGE_W + OFFS_W,
    localparam int LOCAL_W    = OFFS_W + 2
) (
    input  logic [PHYS_W-1:0]  phys_addr,
    output logic               sel_main,
    output logic               sel_disp,
    output logic               sel_boot,
    output logic               unmapped,
    output logic [LOCAL_W-1:0] dev_addr
);

    localparam logic [LOCAL_W-1:0] DISP_HI_BASE = LOCAL_W'(1) << OFFS_W;

    region_e           rgn;
    logic [PAGE_W-1:0] page;

    assign page = phys_addr[PHYS_W-1:OFFS_W];
    assign rgn  = classify_page(page);

    always_comb begin
        sel_main = 1'b0;
        sel_disp = 1'b0;
        sel_boot = 1'b0;
        unmapped = 1'b0;
        dev_addr = '0;
        unique case (rgn)
            RGN_MAIN: begin
                sel_main = 1'b1;
                dev_addr = phys_addr[LOCAL_W-1:0];
            end
            RGN_DISP_LO: begin
                sel_disp = 1'b1;
                dev_addr = LOCAL_W'(phys_addr[OFFS_W-1:0]);
            end
            RGN_DISP_HI: begin
                sel_disp = 1'b1;
                dev_addr = DISP_HI_BASE | LOCAL_W'(phys_addr[DISP_TAIL_W-1:0]);
            end
            RGN_BOOT: begin
                sel_boot = 1'b1;
                dev_addr = LOCAL_W'(phys_addr[BOOT_W-1:0]);
            end
            default: begin
                unmapped = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/paged_addr_mapper.sv
module paged_addr_mapper #(
    parameter int SEL_W       = 2,
    parameter int OFFS_W      = 14,
    parameter int DATA_W      = 8,
    parameter int DISP_TAIL_W = 12,
    parameter int BOOT_W      = 11,
    localparam int PAGE_W     = paged_map_pkg::PAGE_BITS,
    localparam int N_REG      = 1 << SEL_W,
    localparam int LOG_W      = SEL_W + OFFS_W,
    localparam int PHYS_W     = PAGE_W + OFFS_W,
    localparam int LOCAL_W    = OFFS_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_wr_en,
    input  logic [SEL_W-1:0]   map_wr_sel,
    input  logic [DATA_W-1:0]  map_wr_data,
    input  logic [LOG_W-1:0]   cpu_addr,
    output logic [PHYS_W-1:0]  phys_addr,
    output logic               sel_main,
    output logic               sel_disp,
    output logic               sel_boot,
    output logic               unmapped,
    output logic [LOCAL_W-1:0] dev_addr
);

    logic [N_REG*PAGE_W-1:0] page_regs;

    pm_page_regs #(
        .SEL_W  (SEL_W),
        .PAGE_W (PAGE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (map_wr_en),
        .wr_sel    (map_wr_sel),
        .wr_page   (map_wr_data[PAGE_W-1:0]),
        .regs_flat (page_regs)
    );

    pm_xlate #(
        .SEL_W  (SEL_W),
        .OFFS_W (OFFS_W),
        .PAGE_W (PAGE_W)
    ) u_xlate (
        .cpu_addr  (cpu_addr),
        .regs_flat (page_regs),
        .phys_addr (phys_addr)
    );

    pm_region #(
        .OFFS_W      (OFFS_W),
        .DISP_TAIL_W (DISP_TAIL_W),
        .BOOT_W      (BOOT_W)
    ) u_region (
        .phys_addr (phys_addr),
        .sel_main  (sel_main),
        .sel_disp  (sel_disp),
        .sel_boot  (sel_boot),
        .unmapped  (unmapped),
        .dev_addr  (dev_addr)
    );

endmodule

// File: rtl/paged_addr_mapper_chk.sv
module paged_addr_mapper_chk #(
    parameter int SEL_W   = 2,
    parameter int OFFS_W  = 14,
    parameter int DATA_W  = 8,
    parameter int PAGE_W  = 4,
    parameter int BOOT_W  = 11,
    localparam int N_REG   = 1 << SEL_W,
    localparam int LOG_W   = SEL_W + OFFS_W,
    localparam int PHYS_W  = PAGE_W + OFFS_W,
    localparam int LOCAL_W = OFFS_W + 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    map_wr_en,
    input logic [SEL_W-1:0]        map_wr_sel,
    input logic [DATA_W-1:0]       map_wr_data,
    input logic [LOG_W-1:0]        cpu_addr,
    input logic [PHYS_W-1:0]       phys_addr,
    input logic                    sel_main,
    input logic                    sel_disp,
    input logic                    sel_boot,
    input logic                    unmapped,
    input logic [LOCAL_W-1:0]      dev_addr,
    input logic [N_REG*PAGE_W-1:0] page_regs
);

    for (genvar i = 0; i < N_REG; i++) begin : g_chk
        // R1: identity map right after reset release
        assert_reset_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> page_regs[i*PAGE_W +: PAGE_W] == PAGE_W'(i));

        // R2: a write lands in the addressed register
        assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (map_wr_en && map_wr_sel == SEL_W'(i)) |=>
                page_regs[i*PAGE_W +: PAGE_W] == $past(map_wr_data[PAGE_W-1:0]));

        // R10: no write to this register means no change
        assert_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(map_wr_en && map_wr_sel == SEL_W'(i)) |=>
                $stable(page_regs[i*PAGE_W +: PAGE_W]));

        // R3: page bits follow the register picked by the bank bits
        assert_page_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_addr[LOG_W-1:OFFS_W] == SEL_W'(i)) |->
                phys_addr[PHYS_W-1:OFFS_W] == page_regs[i*PAGE_W +: PAGE_W]);
    end

    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]);

    assert_main_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_main |-> phys_addr[PHYS_W-1:LOCAL_W] == '0);

    assert_boot_fold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_boot |-> dev_addr[LOCAL_W-1:BOOT_W] == '0);

    assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (dev_addr == '0));

    assert_one_region_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_main, sel_disp, sel_boot, unmapped}) == 1);

endmodule

bind paged_addr_mapper paged_addr_mapper_chk #(
    .SEL_W  (SEL_W),
    .OFFS_W (OFFS_W),
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W),
    .BOOT_W (BOOT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .map_wr_en   (map_wr_en),
    .map_wr_sel  (map_wr_sel),
    .map_wr_data (map_wr_data),
    .cpu_addr    (cpu_addr),
    .phys_addr   (phys_addr),
    .sel_main    (sel_main),
    .sel_disp    (sel_disp),
    .sel_boot    (sel_boot),
    .unmapped    (unmapped),
    .dev_addr    (dev_addr),
    .page_regs   (page_regs)
);

// File: tb/tb_paged_addr_mapper.sv
module tb_paged_addr_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_wr_en = 1'b0;
    logic [1:0]  map_wr_sel = '0;
    logic [7:0]  map_wr_data = '0;
    logic [15:0] cpu_addr = '0;
    logic [17:0] phys_addr;
    logic        sel_main, sel_disp, sel_boot, unmapped;
    logic [15:0] dev_addr;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    paged_addr_mapper dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .map_wr_en   (map_wr_en),
        .map_wr_sel  (map_wr_sel),
        .map_wr_data (map_wr_data),
        .cpu_addr    (cpu_addr),
        .phys_addr   (phys_addr),
        .sel_main    (sel_main),
        .sel_disp    (sel_disp),
        .sel_boot    (sel_boot),
        .unmapped    (unmapped),
        .dev_addr    (dev_addr)
    );

    // Entry: {page[3:0], cpu_addr[15:0], sel{main,disp,boot,unm}[3:0], dev_addr[15:0]}
    localparam int NVEC = 18;
    localparam logic [39:0] VEC [NVEC] = '{
        {4'h0, 16'h0123, 4'b1000, 16'h0123},
        {4'h3, 16'h7ABC, 4'b1000, 16'hFABC},
        {4'h2, 16'hC001, 4'b1000, 16'h8001},
        {4'h8, 16'h8FFF, 4'b0100, 16'h0FFF},
        {4'h8, 16'hBFFF, 4'b0100, 16'h3FFF},
        {4'h9, 16'hC000, 4'b0100, 16'h4000},
        {4'h9, 16'hF123, 4'b0100, 16'h4123},
        {4'h9, 16'h1ABC, 4'b0100, 16'h4ABC},
        {4'hC, 16'h4000, 4'b0010, 16'h0000},
        {4'hF, 16'h3FFF, 4'b0010, 16'h07FF},
        {4'hD, 16'h8C55, 4'b0010, 16'h0455},
        {4'hE, 16'hD7FF, 4'b0010, 16'h07FF},
        {4'h4, 16'h0111, 4'b0001, 16'h0000},
        {4'h5, 16'h2222, 4'b0001, 16'h0000},
        {4'h6, 16'hAAAA, 4'b0001, 16'h0000},
        {4'h7, 16'h5555, 4'b0001, 16'h0000},
        {4'hA, 16'h9999, 4'b0001, 16'h0000},
        {4'hB, 16'hEEEE, 4'b0001, 16'h0000}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        map_wr_en   = 1'b1;
        map_wr_sel  = sel;
        map_wr_data = data;
        @(negedge clk);
        map_wr_en   = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a);
        cpu_addr = a;
        #1;
    endtask

    function automatic string region_tag(input logic [3:0] pg, input logic [3:0] s);
        if (s == 4'b1000) return "R4";
        if (s == 4'b0100) return (pg == 4'h8) ? "R5" : "R6";
        if (s == 4'b0010) return "R7";
        return "R8";
    endfunction

    task automatic check_identity(input string tag);
        for (int n = 0; n < 4; n++) begin
            probe({n[1:0], 14'h0155});
            check(tag, "identity phys", 32'(phys_addr), 32'({n[3:0], 14'h0155}));
            check(tag, "identity main", 32'(sel_main), 32'd1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1: identity map after reset
        check_identity("R1");

        // R10: strobe low, select and data driven, map must not move
        @(negedge clk);
        map_wr_sel  = 2'd1;
        map_wr_data = 8'hFF;
        repeat (2) @(negedge clk);
        probe(16'h4000);
        check("R10", "phys with strobe low", 32'(phys_addr), 32'h04000);

        // R2: write with junk upper bits, others unchanged
        do_write(2'd1, 8'hF9);
        probe(16'h4005);
        check("R2", "phys after write", 32'(phys_addr), 32'h24005);
        probe(16'h0000);
        check("R2", "reg0 untouched", 32'(phys_addr), 32'h00000);
        probe(16'h8000);
        check("R2", "reg2 untouched", 32'(phys_addr), 32'h08000);
        probe(16'hC000);
        check("R2", "reg3 untouched", 32'(phys_addr), 32'h0C000);

        // Table walk: R3..R9
        for (int k = 0; k < NVEC; k++) begin
            logic [3:0]  pg;
            logic [15:0] a;
            logic [3:0]  es;
            logic [15:0] el;
            string       tag;
            {pg, a, es, el} = VEC[k];
            tag = region_tag(pg, es);
            do_write(a[15:14], {4'hA, pg});
            probe(a);
            check("R3", "phys_addr", 32'(phys_addr), 32'({pg, a[13:0]}));
            check(tag, "selects", 32'({sel_main, sel_disp, sel_boot, unmapped}), 32'(es));
            check(tag, "dev_addr", 32'(dev_addr), 32'(el));
            check("R9", "one region", 32'($countones({sel_main, sel_disp, sel_boot, unmapped})), 32'd1);
        end

        // R3: address change alone moves the output without a clock edge
        @(negedge clk);
        probe(16'h0010);
        probe(16'h0011);
        check("R3", "same-cycle offset", 32'(phys_addr[13:0]), 32'h0011);

        // R1: a second reset restores identity map
        do_reset();
        @(negedge clk);
        check_identity("R1");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule